// File: doc/BRIEF.md
# Serial Shift Port with Stalling Core Access

This block sits between a processor core and four I/O pins and moves words of 8, 16, 24 or 32 bits over a clocked serial line. The core needs no bit-level pin toggling. The core side is one request channel that uses valid/ready signalling. Each request carries an operation code: write (send only), exchange (send and capture what arrives), read (collect the last captured word), or no operation. When a request cannot complete, the block holds ready low and raises a stall output. The core then waits for the data or for the queue slot. It never polls a status flag.

The block has a one-word transmit queue in front of the bit engine. Software can therefore hand over the next word while the current word is still shifting. The queued word starts on the bit period right after the current word ends.

As clock master, the block produces the shift clock from the system clock through a programmable divider. As a slave, it synchronises an external shift clock and data input into the system clock domain and acts on the edges it detects there. Clock polarity, clock phase, bit order and word length are set by configuration pins.

Top module: `ser_shift_port`

## Requirements
- R1: A write (req_op 2'b01) or exchange (2'b11) is accepted at once while the queue slot is empty. While the slot holds a word, req_ready is low for these codes, and the word is kept until the slot empties. Code 2'b00 is always ready and has no effect.
- R2: A read (req_op 2'b10) holds req_ready low until a captured word is waiting. It then completes with rsp_valid high and the word on rsp_rdata, and it consumes that word.
- R3: cfg_len selects the word size: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. The received bits sit right-aligned in rsp_rdata, and the unused upper bits read zero.
- R4: With cfg_lsb_first at 0, bit len-1 of the word goes out first and the first received bit lands in bit len-1. With cfg_lsb_first at 1, bit 0 goes out first and the first received bit lands in bit 0.
- R5: A word waiting in the queue slot starts on the bit period right after the previous word's last trailing edge. No idle clock period appears between the two words.
- R6: A write drives data out without capturing the input pin, so no word becomes readable. An exchange captures one bit per sample edge and makes its word readable in the cycle after the last trailing edge.
- R7: In master mode, each half period of sclk_out lasts cfg_div system clocks, and cfg_div of 0 acts as 1. Between transfers, sclk_out rests at cfg_cpol.
- R8: With cfg_cpha at 0, input is sampled on the leading edge and output changes on the trailing edge. With cfg_cpha at 1, output changes on the leading edge and input is sampled on the trailing edge. The leading edge is the edge away from the idle level.
- R9: In slave mode, sclk_in and miso_in pass through two-flop synchronisers, and the edges of sclk_in are found in the system clock domain. sclk_out stays at cfg_cpol. sclk_in must run no faster than a quarter of the system clock.
- R10: stall is high exactly while req_valid is high and the request cannot be accepted in that cycle.
- R11: After reset, no transfer is running, the queue slot and the receive word are empty, mosi is 0 and sclk_out is at cfg_cpol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the shift clock; 0: follow sclk_in |
| cfg_cpol | input | 1 | Idle level of the shift clock |
| cfg_cpha | input | 1 | Selects the sample edge (see R8) |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_len | input | 2 | Word size code, (code+1) bytes |
| cfg_div | input | 8 | Master half period in system clocks |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 00 none, 01 write, 10 read, 11 exchange |
| req_wdata | input | 32 | Word to send |
| req_ready | output | 1 | Request accepted on this clock edge |
| stall | output | 1 | Core must wait |
| rsp_valid | output | 1 | Read completes in this cycle |
| rsp_rdata | output | 32 | Captured word, right-aligned |
| sclk_in | input | 1 | External shift clock (slave mode) |
| miso_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Generated shift clock |
| mosi | output | 1 | Serial data output |

## Verification
A request is accepted on the clock edge where ready is high. The accepted word moves from the queue slot into the bit engine one edge later. The first master edge follows after cfg_div more clocks. The captured word is readable in the cycle after the last trailing edge. In slave mode, the block reacts to a pin edge about three clocks after it happens.

The bench drives inputs on the falling clock edge and samples outputs there. It reads the serial line as a receiver would: it takes the mosi value from the cycle before each sclk_out transition. The bench counts clock-period gaps between transitions to check the divider and the gapless hand-over. In slave tests it gives each half period of sclk_in six clocks, which leaves a margin of more than one clock over the synchroniser delay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_XCHG  = 2'b11
  } op_e;
endpackage

// File: rtl/ssp_clkgen.sv
// Bit-clock source: divider in master mode, synchronised edge detector in slave mode.
module ssp_clkgen #(
  parameter int DIVW = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            master,
  input  logic            cpol,
  input  logic [DIVW-1:0] div,
  input  logic            active,
  input  logic            sclk_in,
  input  logic            miso_in,
  output logic            lead_ev,
  output logic            trail_ev,
  output logic            sclk_out,
  output logic            din
);
  logic [DIVW-1:0] div_cnt, lim;
  logic            phase, tick;
  logic [SYNC-1:0] ck_sync, dt_sync;
  logic            ck_prev, s_rise, s_fall;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = active && master && (div_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      phase   <= 1'b0;
    end else if (!(active && master)) begin
      div_cnt <= '0;
      phase   <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      phase   <= ~phase;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sync <= '0;
      dt_sync <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC-2:0], sclk_in};
      dt_sync <= {dt_sync[SYNC-2:0], miso_in};
      ck_prev <= ck_sync[SYNC-1];
    end
  end

  assign s_rise   = ck_sync[SYNC-1] & ~ck_prev;
  assign s_fall   = ~ck_sync[SYNC-1] & ck_prev;
  assign lead_ev  = master ? (tick & ~phase) : (active & (cpol ? s_fall : s_rise));
  assign trail_ev = master ? (tick & phase)  : (active & (cpol ? s_rise : s_fall));
  assign sclk_out = master ? (cpol ^ phase) : cpol;
  assign din      = master ? miso_in : dt_sync[SYNC-1];
endmodule

// File: rtl/ssp_shifter.sv
// Bit engine: indexes one word in and out, sampling on the phase-selected edge.
module ssp_shifter #(
  parameter int DW   = 32,
  parameter int LENW = 2,
  parameter int IDXW = LENW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpha,
  input  logic            lead_ev,
  input  logic            trail_ev,
  input  logic            din,
  input  logic            ld_req,
  input  logic [DW-1:0]   ld_word,
  input  logic            ld_cap,
  input  logic [LENW-1:0] ld_len,
  input  logic            ld_lsb,
  output logic            active,
  output logic            pop,
  output logic            end_ev,
  output logic            done_cap,
  output logic [DW-1:0]   rx_data,
  output logic            mosi
);
  logic [DW-1:0]   word, acc, acc_nx;
  logic            cap, lsb, first, samp;
  logic [LENW-1:0] len;
  logic [IDXW-1:0] idx, last, pos;

  assign last   = {len, 3'b111};
  assign pos    = lsb ? idx : (last - idx);
  assign end_ev = active && trail_ev && (idx == last);
  assign pop    = ld_req && (!active || end_ev);
  assign samp   = active && (cpha ? trail_ev : lead_ev);

  always_comb begin
    acc_nx = acc;
    if (samp) acc_nx[pos] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      word   <= '0;
      acc    <= '0;
      cap    <= 1'b0;
      lsb    <= 1'b0;
      len    <= '0;
      idx    <= '0;
      first  <= 1'b0;
    end else if (pop) begin
      active <= 1'b1;
      word   <= ld_word;
      cap    <= ld_cap;
      lsb    <= ld_lsb;
      len    <= ld_len;
      idx    <= '0;
      first  <= 1'b1;
      acc    <= '0;
    end else if (end_ev) begin
      active <= 1'b0;
    end else if (active) begin
      acc <= acc_nx;
      if (cpha) begin
        if (lead_ev) begin
          if (first) first <= 1'b0;
          else       idx   <= idx + 1'b1;
        end
      end else if (trail_ev) begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign rx_data  = acc_nx;
  assign done_cap = end_ev && cap;
  assign mosi     = active ? word[pos] : 1'b0;
endmodule

// File: rtl/ssp_core_if.sv
// Core-side request channel: one-word send slot, received-word register, stall logic.
module ssp_core_if
  import ssp_pkg::*;
#(
  parameter int DW   = 32,
  parameter int LENW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [DW-1:0]   req_wdata,
  input  logic [LENW-1:0] cfg_len,
  input  logic            cfg_lsb,
  input  logic            pop,
  input  logic            done_cap,
  input  logic [DW-1:0]   rx_data,
  output logic            req_ready,
  output logic            stall,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            hold_full,
  output logic [DW-1:0]   hold_word,
  output logic            hold_cap,
  output logic [LENW-1:0] hold_len,
  output logic            hold_lsb,
  output logic            rx_valid
);
  op_e           op;
  logic          is_rd, is_wr, wr_acc, rd_acc;
  logic [DW-1:0] rx_word;

  assign op        = op_e'(req_op);
  assign is_rd     = (op == OP_READ);
  assign is_wr     = (op == OP_WRITE) || (op == OP_XCHG);
  assign req_ready = is_rd ? rx_valid : (is_wr ? !hold_full : 1'b1);
  assign stall     = req_valid && !req_ready;
  assign wr_acc    = req_valid && is_wr && !hold_full;
  assign rd_acc    = req_valid && is_rd && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_word <= '0;
      hold_cap  <= 1'b0;
      hold_len  <= '0;
      hold_lsb  <= 1'b0;
    end else if (wr_acc) begin
      hold_full <= 1'b1;
      hold_word <= req_wdata;
      hold_cap  <= (op == OP_XCHG);
      hold_len  <= cfg_len;
      hold_lsb  <= cfg_lsb;
    end else if (pop) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else if (done_cap) begin
      rx_valid <= 1'b1;
      rx_word  <= rx_data;
    end else if (rd_acc) begin
      rx_valid <= 1'b0;
    end
  end

  assign rsp_valid = rd_acc;
  assign rsp_rdata = rx_word;
endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port #(
  parameter int DW   = 32,
  parameter int DIVW = 8,
  parameter int SYNC = 2,
  localparam int LENW = $clog2(DW / 8),
  localparam int IDXW = LENW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic [LENW-1:0] cfg_len,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            stall,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  input  logic            sclk_in,
  input  logic            miso_in,
  output logic            sclk_out,
  output logic            mosi
);
  logic            lead_ev, trail_ev, din;
  logic            active, pop, end_ev, end_cap;
  logic [DW-1:0]   rx_data, hold_word;
  logic            hold_full, hold_cap, hold_lsb, rx_valid;
  logic [LENW-1:0] hold_len;

  ssp_clkgen #(.DIVW(DIVW), .SYNC(SYNC)) u_clk (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .cpol(cfg_cpol), .div(cfg_div),
    .active(active), .sclk_in(sclk_in), .miso_in(miso_in),
    .lead_ev(lead_ev), .trail_ev(trail_ev), .sclk_out(sclk_out), .din(din)
  );

  ssp_shifter #(.DW(DW), .LENW(LENW), .IDXW(IDXW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .lead_ev(lead_ev), .trail_ev(trail_ev),
    .din(din), .ld_req(hold_full), .ld_word(hold_word), .ld_cap(hold_cap),
    .ld_len(hold_len), .ld_lsb(hold_lsb), .active(active), .pop(pop),
    .end_ev(end_ev), .done_cap(end_cap), .rx_data(rx_data), .mosi(mosi)
  );

  ssp_core_if #(.DW(DW), .LENW(LENW)) u_if (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .cfg_len(cfg_len), .cfg_lsb(cfg_lsb_first),
    .pop(pop), .done_cap(end_cap), .rx_data(rx_data),
    .req_ready(req_ready), .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hold_full(hold_full), .hold_word(hold_word), .hold_cap(hold_cap),
    .hold_len(hold_len), .hold_lsb(hold_lsb), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic       cfg_cpol,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_ready,
  input logic       stall,
  input logic       sclk_out,
  input logic       active,
  input logic       hold_full,
  input logic       end_ev,
  input logic       end_cap,
  input logic       rx_valid
);
  a_r10_stall_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> req_valid);

  a_r1_full_slot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[0] && hold_full) |-> !req_ready);

  a_r5_reload_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && hold_full) |=> active);

  a_r6_write_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && !end_cap && !(req_valid && req_op == 2'b10 && req_ready))
      |=> (rx_valid == $past(rx_valid)));

  a_r7_clock_only_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(sclk_out) && $stable(cfg_cpol)) |-> $past(active));

  a_r9_slave_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (sclk_out == cfg_cpol));
endmodule

bind ser_shift_port ssp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready), .stall(stall),
  .sclk_out(sclk_out), .active(active), .hold_full(hold_full), .end_ev(end_ev),
  .end_cap(end_cap), .rx_valid(rx_valid)
);

// File: tb/tb_ser_shift_port.sv
module tb_ser_shift_port;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  len;
    logic        lsb;
    logic        cpol;
    logic        cpha;
    logic [7:0]  div;
    logic [31:0] word;
    logic [31:0] rx;
    logic [31:0] wire_v;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 32'h123456A5, 32'h000000A5, 32'h000000A5},
    '{2'd1, 1'b0, 1'b1, 1'b1, 8'd2, 32'hCAFE1234, 32'h00001234, 32'h00001234},
    '{2'd3, 1'b0, 1'b0, 1'b1, 8'd1, 32'h80000001, 32'h80000001, 32'h80000001},
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'd1, 32'h00000013, 32'h00000013, 32'h000000C8},
    '{2'd2, 1'b1, 1'b1, 1'b0, 8'd3, 32'hFF000F01, 32'h00000F01, 32'h0080F000},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'd0, 32'h00000003, 32'h00000003, 32'hC0000000}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0;
  logic [1:0] cfg_len = 0;
  logic [7:0] cfg_div = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, stall, rsp_valid, sclk_out, mosi;
  logic [31:0] rsp_rdata;
  logic sclk_in = 0, miso_drv = 0, loop_en = 1;
  logic miso_in;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  int tog_cnt = 0, t_first = 0, t_second = 0, t_last = 0, wire_n = 0;
  logic [31:0] wire_bits = 0;
  logic sc_last = 0, mosi_last = 0;

  assign miso_in = loop_en ? mosi : miso_drv;

  ser_shift_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata),
    .req_ready(req_ready), .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sclk_in(sclk_in), .miso_in(miso_in), .sclk_out(sclk_out), .mosi(mosi)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // Line observer: takes the mosi value held before each sample-edge transition.
  always @(negedge clk) begin
    if (sclk_out !== sc_last) begin
      tog_cnt++;
      if (tog_cnt == 1) t_first = cyc;
      if (tog_cnt == 2) t_second = cyc;
      t_last = cyc;
      if (cfg_cpha ? (sclk_out == cfg_cpol) : (sclk_out != cfg_cpol)) begin
        wire_bits = {wire_bits[30:0], mosi_last};
        wire_n++;
      end
    end
    sc_last   = sclk_out;
    mosi_last = mosi;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk);
    tog_cnt = 0; wire_bits = 0; wire_n = 0;
  endtask

  task automatic push(input logic [1:0] op, input logic [31:0] w, output int waited);
    @(negedge clk);
    req_valid = 1; req_op = op; req_wdata = w; waited = 0;
    #1;
    while (!req_ready) begin @(negedge clk); #1; waited++; end
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  task automatic pull(output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_op = 2'b10;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    d = rsp_rdata; v = rsp_valid;
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    logic [31:0] d;
    logic v;
    logic [7:0] cap_bits;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 sclk_out idle", sclk_out, 0);
    check("R11 mosi idle", mosi, 0);
    check("R11 ready with no request", req_ready, 1);
    check("R11 R10 stall low", stall, 0);

    // R2 R10: read with nothing captured must stall
    req_valid = 1; req_op = 2'b10;
    repeat (20) @(negedge clk);
    #1;
    check("R2 read not ready", req_ready, 0);
    check("R10 stall on blocked read", stall, 1);
    check("R2 no response", rsp_valid, 0);
    @(negedge clk); req_valid = 0; req_op = 0;

    // Table: master loopback exchanges
    foreach (VECS[i]) begin
      @(negedge clk);
      cfg_master = 1; cfg_len = VECS[i].len; cfg_lsb_first = VECS[i].lsb;
      cfg_cpol = VECS[i].cpol; cfg_cpha = VECS[i].cpha; cfg_div = VECS[i].div;
      repeat (3) @(negedge clk);
      mon_clear();
      push(2'b11, VECS[i].word, w);
      check("R1 exchange accepted at once", w, 0);
      pull(d, v);
      check("R2 read completes", {31'd0, v}, 1);
      check("R3 R6 received word", d, VECS[i].rx);
      check("R4 R8 wire order", wire_bits, VECS[i].wire_v);
      check("R3 bit count", wire_n, 8 * (VECS[i].len + 1));
      check("R7 half period", t_second - t_first, (VECS[i].div == 0) ? 1 : VECS[i].div);
      repeat (4) @(negedge clk);
      check("R7 idle level", sclk_out, VECS[i].cpol);
    end

    // R6: write-only leaves nothing to read
    @(negedge clk);
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_len = 0; cfg_div = 1;
    repeat (3) @(negedge clk);
    push(2'b01, 32'h000000FF, w);
    repeat (40) @(negedge clk);
    req_valid = 1; req_op = 2'b10;
    repeat (5) @(negedge clk);
    #1;
    check("R6 write does not capture", req_ready, 0);
    @(negedge clk); req_valid = 0; req_op = 0;

    // R1 R5: back-to-back writes stream without gaps
    mon_clear();
    push(2'b01, 32'h000000A1, w);
    check("R1 first write no wait", w, 0);
    push(2'b01, 32'h000000B2, w);
    check("R1 second write fills slot", w, 0);
    push(2'b01, 32'h000000C3, w);
    check("R1 third write back-pressured", {31'd0, (w > 0)}, 1);
    repeat (60) @(negedge clk);
    check("R5 toggle count", tog_cnt, 48);
    check("R5 no gap between words", t_last - t_first, 47);
    check("R5 last word on wire", wire_bits[7:0], 8'hC3);

    // R9: slave mode exchange
    @(negedge clk);
    cfg_master = 0; loop_en = 0; sclk_in = 0; miso_drv = 0;
    repeat (3) @(negedge clk);
    check("R9 sclk_out parked", sclk_out, 0);
    push(2'b11, 32'h000000A7, w);
    repeat (4) @(negedge clk);
    cap_bits = 0;
    for (int b = 7; b >= 0; b--) begin
      miso_drv = 8'h3C >> b;
      repeat (6) @(negedge clk);
      cap_bits = {cap_bits[6:0], mosi};
      sclk_in = 1;
      repeat (6) @(negedge clk);
      sclk_in = 0;
    end
    pull(d, v);
    check("R9 slave received", d, 32'h0000003C);
    check("R9 slave sent", cap_bits, 8'hA7);
    check("R9 sclk_out stays idle", sclk_out, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule